// File: doc/BRIEF.md
# PWM Channel Counter Comparator

This block is a single pulse-width-modulated channel. A down-counter walks from a programmed period value to zero on each prescaled tick and then reloads. While it is running, the output is high whenever the count is at or below a programmed compare value. The channel therefore produces a waveform whose period is `period_i + 1` ticks and whose high time is `compare_i + 1` ticks. Two settings are handled as special cases: a zero period and a compare value that reaches the period.

A 4-bit control field drives the channel. Bit 0 enables it, bit 2 inverts the output and bit 3 selects continuous (toggle) operation. Bit 1 is reserved and ignored. The channel runs only while bits 0 and 3 are both set. Otherwise the counter is cleared and the un-inverted output is low. The invert bit acts on the pin combinationally at all times, including while the channel is stopped. Period and compare values are captured into shadow registers when the channel starts and again at each reload, so a write in mid-period never produces a truncated pulse. A one-cycle pulse on `period_end_o` marks every reload.

Top module: `pwm_channel`

## Requirements
- R1: The channel runs only when control bit 0 (enable) and bit 3 (continuous) are both 1. Enable alone, continuous alone or reserved bit 1 does not start it, and bit 1 has no effect on a running channel.
- R2: While the channel is not running, the un-inverted output is 0 and `period_end_o` is 0.
- R3: With a tick on every cycle, a running channel with period value P > 0 asserts `period_end_o` for one cycle every P + 1 ticks, in the cycle after the tick that reloads the count.
- R4: With 0 < C < P, the un-inverted output is high for exactly C + 1 ticks of each P + 1 tick period. These are the last C + 1 counts of the down-count, and the first count after start or reload is P.
- R5: A period value of 0 gives a constant low un-inverted output while running.
- R6: A compare value greater than or equal to a nonzero period value gives a constant high un-inverted output while running.
- R7: Control bit 2 complements the pin in the same cycle it changes, whether or not the channel is running.
- R8: Toggling only the invert bit on a running channel flips the polarity and does not restart or shift the count.
- R9: The period and compare values are sampled when the channel starts and at each reload. Changes at other times take effect only at the next reload.
- R10: The count advances only on cycles with `tick_en` high. Other cycles hold the output and produce no `period_end_o`.
- R11: During and right after reset, with the control field at 0, `pwm_o` and `period_end_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled tick; one count step per high cycle |
| period_i | input | CNT_W | Period value; period is this + 1 ticks |
| compare_i | input | CNT_W | Compare value; high time is this + 1 ticks |
| ctrl_i | input | 4 | Bit 0 enable, bit 1 reserved, bit 2 invert, bit 3 continuous |
| pwm_o | output | 1 | PWM pin |
| period_end_o | output | 1 | One-cycle pulse on each reload |

## Verification
The main sweep covers every period from 0 to 4, every compare value from 0 to 5 and both polarities. It runs two full periods of each combination, so the zero-period case, the compare-at-or-above-period case and the normal duty ratios are each told apart from their neighbours. A sparse tick pattern separates counting per tick from counting per clock. A mid-period change of period and compare shows whether the shadow registers defer the new values to the reload. An invert flip in mid-run, together with control words that set only one of the two run bits, shows that polarity and run gating stay separate from the count.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int CTRL_W   = 4;
    localparam int EN_POS   = 0;
    localparam int INV_POS  = 2;
    localparam int CONT_POS = 3;

    typedef struct packed {
        logic run;
        logic inv;
    } chan_mode_t;
endpackage

// File: rtl/pwm_ctrl_decode.sv
module pwm_ctrl_decode
    import pwm_chan_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    output chan_mode_t        mode_o
);
    logic unused_rsvd;

    always_comb begin
        mode_o.run = ctrl_i[EN_POS] & ctrl_i[CONT_POS];
        mode_o.inv = ctrl_i[INV_POS];
    end

    assign unused_rsvd = ctrl_i[1];
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] compare_o,
    output logic             reload_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic             pend;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (!run_i) begin
            st_d.running = 1'b0;
            st_d.cnt     = ZERO;
        end else if (!st_q.running) begin
            st_d.running = 1'b1;
            st_d.cnt     = period_i;
            st_d.per     = period_i;
            st_d.cmp     = compare_i;
        end else if (tick_i) begin
            if (st_q.cnt == ZERO) begin
                st_d.cnt  = period_i;
                st_d.per  = period_i;
                st_d.cmp  = compare_i;
                st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o = st_q.running;
    assign count_o   = st_q.cnt;
    assign period_o  = st_q.per;
    assign compare_o = st_q.cmp;
    assign reload_o  = st_q.pend;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic             run_i,
    input  logic             running_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic             level_o
);
    logic zero_per, full_on, in_window;

    always_comb begin
        zero_per  = (period_i == '0);
        full_on   = (compare_i >= period_i);
        in_window = (count_i <= compare_i);
        level_o   = run_i & running_i & ~zero_per & (full_on | in_window);
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [3:0]       ctrl_i,
    output logic             pwm_o,
    output logic             period_end_o
);
    chan_mode_t       mode;
    logic             ctr_running;
    logic [CNT_W-1:0] ctr_count;
    logic [CNT_W-1:0] ctr_period;
    logic [CNT_W-1:0] ctr_compare;
    logic             ctr_reload;
    logic             raw_level;

    pwm_ctrl_decode u_dec (
        .ctrl_i (ctrl_i),
        .mode_o (mode)
    );

    pwm_period_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (mode.run),
        .tick_i    (tick_en),
        .period_i  (period_i),
        .compare_i (compare_i),
        .running_o (ctr_running),
        .count_o   (ctr_count),
        .period_o  (ctr_period),
        .compare_o (ctr_compare),
        .reload_o  (ctr_reload)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .run_i     (mode.run),
        .running_i (ctr_running),
        .count_i   (ctr_count),
        .period_i  (ctr_period),
        .compare_i (ctr_compare),
        .level_o   (raw_level)
    );

    assign pwm_o        = raw_level ^ mode.inv;
    assign period_end_o = ctr_reload & mode.run;
endmodule

// File: rtl/pwm_channel_checker.sv
module pwm_channel_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [3:0]       ctrl_i,
    input logic             pwm_o,
    input logic             period_end_o,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period
);
    // R2, R7
    a_r2_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_i[0] && ctrl_i[3]) |-> (pwm_o == ctrl_i[2]) && !period_end_o);

    // R5
    a_r5_zero_period_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[0] && ctrl_i[3] && period == '0) |-> (pwm_o == ctrl_i[2]));

    // R10
    a_r10_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |-> $past(tick_en));

    // R4
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count <= period));

    // R9
    a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$past(running && tick_en && count == '0))
        |-> $stable(period));
endmodule

bind pwm_channel pwm_channel_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .ctrl_i       (ctrl_i),
    .pwm_o        (pwm_o),
    .period_end_o (period_end_o),
    .running      (ctr_running),
    .count        (ctr_count),
    .period       (ctr_period)
);

// File: tb/sim_pwm_channel.sv
module sim_pwm_channel;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [W-1:0] period_i = '0;
    logic [W-1:0] compare_i = '0;
    logic [3:0]   ctrl_i = 4'b0000;
    logic         pwm_o, period_end_o;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    pwm_channel #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_i(period_i),
        .compare_i(compare_i), .ctrl_i(ctrl_i), .pwm_o(pwm_o),
        .period_end_o(period_end_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_raw(int p, int c, int k);
        int cur;
        if (p == 0) return 1'b0;
        if (c >= p) return 1'b1;
        cur = p - (k % (p + 1));
        return (cur <= c);
    endfunction

    function automatic string tag_for(int p, int c);
        if (p == 0) return "R5";
        if (c >= p) return "R6";
        return "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic inv_b;
        int   k;
        // R11 reset state
        repeat (2) @(negedge clk);
        chk("R11 pwm in reset", pwm_o, 1'b0);
        chk("R11 pulse in reset", period_end_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pwm after reset", pwm_o, 1'b0);
        chk("R11 pulse after reset", period_end_o, 1'b0);

        // Sweep: R3 R4 R5 R6 R7 R2
        tick_en = 1'b1;
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 6; c++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    inv_b     = iv[0];
                    ctrl_i    = {1'b0, inv_b, 2'b00};
                    period_i  = W'(p);
                    compare_i = W'(c);
                    @(negedge clk);
                    chk("R2 stopped level", pwm_o, inv_b);
                    chk("R2 stopped pulse", period_end_o, 1'b0);
                    ctrl_i = {1'b1, inv_b, 1'b0, 1'b1};
                    @(negedge clk);
                    for (int i = 0; i < 2 * (p + 1) + 1; i++) begin
                        chk(tag_for(p, c), pwm_o, exp_raw(p, c, i) ^ inv_b);
                        chk("R3 period end", period_end_o,
                            (i > 0) && (i % (p + 1) == 0));
                        @(negedge clk);
                    end
                end
            end
        end

        // R1: only one run bit set, and reserved bit alone
        period_i = 16'd3; compare_i = 16'd3;
        foreach (ctrl_i[b]) begin end
        ctrl_i = 4'b0001;
        repeat (3) begin @(negedge clk); chk("R1 enable only", pwm_o, 1'b0); end
        ctrl_i = 4'b1000;
        repeat (3) begin @(negedge clk); chk("R1 mode only", pwm_o, 1'b0); end
        ctrl_i = 4'b0010;
        repeat (2) begin @(negedge clk); chk("R1 reserved only", pwm_o, 1'b0); end
        ctrl_i = 4'b1011;
        @(negedge clk);
        chk("R1 reserved bit with run", pwm_o, 1'b1);
        ctrl_i = 4'b0000;
        @(negedge clk);

        // R8: invert flip mid-run, count continues
        period_i = 16'd4; compare_i = 16'd1;
        ctrl_i = 4'b1001;
        @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            inv_b = (i >= 2);
            if (i == 2) begin
                chk("R8 before flip", pwm_o, exp_raw(4, 1, i));
                ctrl_i = 4'b1101;
                #1;
                chk("R7 immediate invert", pwm_o, ~exp_raw(4, 1, i));
            end
            chk("R8 polarity", pwm_o, exp_raw(4, 1, i) ^ inv_b);
            chk("R8 pulse position", period_end_o, (i > 0) && (i % 5 == 0));
            @(negedge clk);
        end
        ctrl_i = 4'b0000;
        @(negedge clk);

        // R9: mid-period change deferred to reload
        period_i = 16'd4; compare_i = 16'd1;
        ctrl_i = 4'b1001;
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            if (i == 1) begin period_i = 16'd2; compare_i = 16'd2; end
            if (i < 5) begin
                chk("R9 old values held", pwm_o, exp_raw(4, 1, i));
                chk("R9 old period", period_end_o, 1'b0);
            end else begin
                chk("R9 new values", pwm_o, 1'b1);
                chk("R9 new period", period_end_o, (i == 5) || (i == 8));
            end
            @(negedge clk);
        end
        ctrl_i = 4'b0000;
        @(negedge clk);

        // R10: sparse ticks
        period_i = 16'd3; compare_i = 16'd1;
        ctrl_i = 4'b1001;
        tick_en = 1'b0;
        @(negedge clk);
        k = 0;
        for (int i = 0; i < 20; i++) begin
            logic t;
            t = (i % 3 == 1);
            tick_en = t;
            @(negedge clk);
            if (t) k++;
            chk("R10 tick gated level", pwm_o, exp_raw(3, 1, k));
            chk("R10 tick gated pulse", period_end_o, t && (k % 4 == 0));
        end
        ctrl_i = 4'b0000;
        tick_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule